// File: doc/BRIEF.md
# I2C SCL Waveform Divider

This block times the serial clock of an I2C master from one system clock. A 19-bit waveform word holds a divider for the low phase, a divider for the high phase and an exponent that both share. A phase lasts its divider shifted left by the exponent, plus a fixed offset set at build time. The block drives the SCL level that the bit engine puts on the bus. It also gives three single-cycle strobes: the first cycle of a low phase, the first counted cycle of a high phase, and the middle of either phase. The middle strobe is where SDA may change during low and where SDA is sampled during high.

The waveform word is captured only when a low phase begins, so a write in the middle of a bit never shortens a phase. After SCL is released, the high-phase count waits until the sensed bus line, passed through a synchronizer, reads high. This lets a slave stretch the clock. When the enable input is low the block rests with SCL released. When the enable input goes high the block starts with a low phase. With equal dividers, the SCL frequency is the system clock divided by twice the phase length, not counting the release-to-sense delay. Typical targets are 100 kHz and up to 400 kHz. Software computes the dividers.

Top module: `scl_wave_gen`

## Requirements
- R1: After reset, and for as long as `enable` stays low, `scl_o` is 1 and none of `fall_stb`, `rise_stb` or `mid_stb` is asserted.
- R2: `wave_cfg[7:0]` is the low divider, `wave_cfg[15:8]` is the high divider and `wave_cfg[18:16]` is the exponent E. SCL stays low for exactly low_div * 2^E + OFFSET cycles, counted from the `fall_stb` cycle.
- R3: The high phase lasts exactly high_div * 2^E + OFFSET cycles, counted from the `rise_stb` cycle up to the next `fall_stb` or the return to idle.
- R4: An exponent above MAX_EXP is treated as MAX_EXP in both phase lengths.
- R5: `rise_stb` never occurs while the synchronized sense input is low. When the bus line is released k cycles after SCL is released, the first `rise_stb` comes k + SYNC_STAGES + 1 cycles after the first cycle with `scl_o` = 1 (k = 0 when the line follows `scl_o` at once).
- R6: `wave_cfg` is sampled only at the clock edge that starts a low phase. A change during a bit changes neither its low phase nor its high phase.
- R7: The cycle after an edge at which `enable` is high in idle is a low phase with `fall_stb`. When `enable` is low at the last high-phase cycle, the block returns to idle with `scl_o` = 1 and no further strobes. Until then, the current bit finishes in full.
- R8: `mid_stb` occurs exactly once in each phase, at offset floor(L/2) cycles after that phase's start strobe, where L is the phase length. It never coincides with `fall_stb` or `rise_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Run request from the bit engine |
| wave_cfg | input | 19 | Waveform word: low divider, high divider, exponent |
| scl_sense | input | 1 | Bus SCL as seen at the pad, asynchronous |
| scl_o | output | 1 | SCL level to drive, 0 = pull low, 1 = release |
| fall_stb | output | 1 | First cycle of a low phase |
| rise_stb | output | 1 | First counted cycle of a high phase |
| mid_stb | output | 1 | Middle cycle of the current low or high phase |

## Verification
Every internal state error reaches the ports within one bit period. A wrong phase counter or a stale captured length makes a low or high phase one cycle longer or shorter. A wrong state makes SCL rise early or a strobe appear out of place, so the fault shows at the next phase boundary. A stuck synchronizer or a missed wait shows at the very next release, as a `rise_stb` too early or too late. A capture at the wrong edge shows in the bit that follows a mid-bit reconfiguration. The scoreboard measures each phase, each middle strobe and each release wait against lengths it computes on its own.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

  localparam int unsigned DIV_W   = 8;
  localparam int unsigned EXP_W   = 3;
  localparam int unsigned EXP_LSB = 2 * DIV_W;
  localparam int unsigned CFG_W   = 2 * DIV_W + EXP_W;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } phase_e;

  // Exponent clipped to the build-time ceiling.
  function automatic int unsigned eff_exp(input logic [EXP_W-1:0] ex,
                                          input int unsigned max_exp);
    return (32'(ex) > max_exp) ? max_exp : 32'(ex);
  endfunction

  // Phase length in system clocks.
  function automatic int unsigned phase_len(input logic [DIV_W-1:0] div,
                                            input logic [EXP_W-1:0] ex,
                                            input int unsigned max_exp,
                                            input int unsigned offset);
    return (32'(div) << eff_exp(ex, max_exp)) + offset;
  endfunction

endpackage

// File: rtl/scl_sense_sync.sv
module scl_sense_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  generate
    if (STAGES == 0) begin : g_pass
      assign q_sync = d_async;
    end else begin : g_ff
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= (sh_q << 1) | STAGES'(d_async);
      end
      assign q_sync = sh_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/scl_cfg_hold.sv
module scl_cfg_hold
  import scl_div_pkg::*;
#(
  parameter int unsigned OFFSET  = 4,
  parameter int unsigned MAX_EXP = 7,
  parameter int unsigned LEN_W   = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [CFG_W-1:0]          wave_cfg,
  output logic [1:0][LEN_W-1:0]     len_o
);
  // index 0 = low phase, 1 = high phase
  for (genvar p = 0; p < 2; p++) begin : g_ph
    logic [LEN_W-1:0] len_d, len_r;
    assign len_d = LEN_W'(phase_len(wave_cfg[p*DIV_W +: DIV_W],
                                    wave_cfg[EXP_LSB +: EXP_W],
                                    MAX_EXP, OFFSET));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    len_r <= LEN_W'(OFFSET);
      else if (load) len_r <= len_d;
    end
    assign len_o[p] = len_r;
  end
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_div_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             scl_hi,
  input  logic [LEN_W-1:0] len_lo,
  input  logic [LEN_W-1:0] len_hi,
  output logic             load,
  output logic             scl_o,
  output logic             fall_stb,
  output logic             rise_stb,
  output logic             mid_stb
);
  phase_e           st_q, st_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] cur_len;
  logic             last_cyc;
  logic             counting;

  assign cur_len  = (st_q == PH_HIGH) ? len_hi : len_lo;
  assign last_cyc = (cnt_q == cur_len - LEN_W'(1));
  assign counting = (st_q == PH_LOW) || (st_q == PH_HIGH);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q + LEN_W'(1);
    load  = 1'b0;
    case (st_q)
      PH_IDLE: begin
        cnt_d = '0;
        if (enable) begin
          st_d = PH_LOW;
          load = 1'b1;
        end
      end
      PH_LOW: begin
        if (last_cyc) begin
          st_d  = PH_WAIT;
          cnt_d = '0;
        end
      end
      PH_WAIT: begin
        cnt_d = '0;
        if (scl_hi) st_d = PH_HIGH;
      end
      PH_HIGH: begin
        if (last_cyc) begin
          cnt_d = '0;
          if (enable) begin
            st_d = PH_LOW;
            load = 1'b1;
          end else begin
            st_d = PH_IDLE;
          end
        end
      end
      default: begin
        st_d  = PH_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign scl_o    = (st_q != PH_LOW);
  assign fall_stb = (st_q == PH_LOW)  && (cnt_q == '0);
  assign rise_stb = (st_q == PH_HIGH) && (cnt_q == '0);
  assign mid_stb  = counting && (cnt_q == (cur_len >> 1));

  // R2
  low_within_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_LOW) |-> (cnt_q < len_lo));

  // R3
  high_within_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_HIGH) |-> (cnt_q < len_hi));

  // R5
  rise_after_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> $past(scl_hi));

  // R6
  len_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == PH_WAIT) || (st_q == PH_HIGH) || ((st_q == PH_LOW) && (cnt_q != '0)))
      |-> ($stable(len_lo) && $stable(len_hi)));

  // R7
  fall_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_o) |-> $past(enable));

  // R8
  strobes_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fall_stb, rise_stb, mid_stb}));

endmodule

// File: rtl/scl_wave_gen.sv
module scl_wave_gen
  import scl_div_pkg::*;
#(
  parameter int unsigned OFFSET      = 4,
  parameter int unsigned MAX_EXP     = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [18:0]      wave_cfg,
  input  logic             scl_sense,
  output logic             scl_o,
  output logic             fall_stb,
  output logic             rise_stb,
  output logic             mid_stb
);
  localparam int unsigned LEN_W = DIV_W + MAX_EXP + 1;

  logic                  scl_hi;
  logic                  load;
  logic [1:0][LEN_W-1:0] len;

  scl_sense_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (scl_sense),
    .q_sync  (scl_hi)
  );

  scl_cfg_hold #(.OFFSET(OFFSET), .MAX_EXP(MAX_EXP), .LEN_W(LEN_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .wave_cfg (wave_cfg),
    .len_o    (len)
  );

  scl_phase_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .scl_hi   (scl_hi),
    .len_lo   (len[0]),
    .len_hi   (len[1]),
    .load     (load),
    .scl_o    (scl_o),
    .fall_stb (fall_stb),
    .rise_stb (rise_stb),
    .mid_stb  (mid_stb)
  );

  // R1
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && scl_o && !load && !rise_stb && !mid_stb) |=> !fall_stb);

endmodule

// File: tb/scl_wave_gen_tb.sv
module scl_wave_gen_tb;
  localparam int OFF  = 3;
  localparam int MAXE = 5;
  localparam int SYNC = 2;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        enable = 0;
  logic [18:0] wave_cfg = '0;
  logic        hold = 0;
  logic        scl_sense;
  logic        scl_o, fall_stb, rise_stb, mid_stb;

  always #4 clk = ~clk;  // 125 MHz

  assign scl_sense = scl_o & ~hold;

  scl_wave_gen #(.OFFSET(OFF), .MAX_EXP(MAXE), .SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wave_cfg(wave_cfg),
    .scl_sense(scl_sense), .scl_o(scl_o), .fall_stb(fall_stb),
    .rise_stb(rise_stb), .mid_stb(mid_stb)
  );

  typedef struct {
    int    lo;
    int    hi;
    int    stretch;
    bit    chk_hi;
    string tag;
  } item_t;

  item_t q[$];
  int n_vec = 0;
  int n_bad = 0;
  int last_span = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic int exp_len(input int div, input int ex);
    int e;
    e = (ex > MAXE) ? MAXE : ex;
    return div * (1 << e) + OFF;
  endfunction

  // driver: push the expected bit, then wait for its low phase to begin
  task automatic send_bit(input int lo, input int hi, input int ex,
                          input int stretch, input bit last, input string tag);
    item_t it;
    it.lo = exp_len(lo, ex);
    it.hi = exp_len(hi, ex);
    it.stretch = stretch;
    it.chk_hi = !last;
    it.tag = tag;
    wave_cfg = {ex[2:0], hi[7:0], lo[7:0]};
    q.push_back(it);
    last_span = it.lo + it.hi + stretch + SYNC + 10;
    enable = 1'b1;
    do @(negedge clk); while (!fall_stb);
    if (last) enable = 1'b0;
  endtask

  task automatic idle_check(input string tag, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk(scl_o && !fall_stb && !rise_stb && !mid_stb,
          {tag, " idle released"}, {scl_o, fall_stb, rise_stb, mid_stb}, 4'b1000);
    end
  endtask

  // monitor
  item_t cur;
  bit cur_v = 0, lo_act = 0, wt_act = 0, hi_act = 0;
  int lo_cnt, hi_cnt, wt_cnt, mid_lo, mid_hi, hold_left;

  always @(negedge clk) begin
    if (rst_n) begin
      if (fall_stb) begin
        if (hi_act && cur_v && cur.chk_hi) begin
          chk(hi_cnt == cur.hi, {cur.tag, " R3 high length"}, hi_cnt, cur.hi);
          chk(mid_hi == (cur.hi >> 1), {cur.tag, " R8 high mid"}, mid_hi, cur.hi >> 1);
        end
        cur_v = 0;
        lo_act = 1; lo_cnt = 0; hi_act = 0; wt_act = 0;
        mid_lo = -1; mid_hi = -1;
      end
      if (lo_act && scl_o) begin
        lo_act = 0;
        if (q.size() == 0) begin
          chk(0, "R7 unexpected bit", 1, 0);
          cur.stretch = 0;
        end else begin
          cur = q.pop_front();
          cur_v = 1;
          chk(lo_cnt == cur.lo, {cur.tag, " low length"}, lo_cnt, cur.lo);
          chk(mid_lo == (cur.lo >> 1), {cur.tag, " R8 low mid"}, mid_lo, cur.lo >> 1);
        end
        wt_act = 1; wt_cnt = 1;
        hold_left = cur.stretch;
        hold = (hold_left > 0);
      end else if (wt_act) begin
        if (rise_stb) begin
          wt_act = 0;
          chk(wt_cnt == cur.stretch + SYNC + 1, "R5 release wait", wt_cnt, cur.stretch + SYNC + 1);
          hi_act = 1; hi_cnt = 0;
        end else begin
          wt_cnt++;
          if (hold_left > 0) hold_left--;
          hold = (hold_left > 0);
        end
      end
      if (lo_act) begin
        if (mid_stb) mid_lo = lo_cnt;
        lo_cnt++;
      end
      if (hi_act) begin
        if (mid_stb) mid_hi = hi_cnt;
        hi_cnt++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(scl_o == 1'b1, "R1 scl in reset", scl_o, 1);
    rst_n = 1'b1;
    idle_check("R1", 12);

    send_bit(5, 5, 1, 0, 0, "R2");      // 13 / 13
    send_bit(0, 0, 0, 0, 0, "R2");      // 3 / 3, shortest phases
    send_bit(10, 3, 2, 0, 0, "R6");     // 43 / 15, loaded mid-bit
    send_bit(2, 1, 7, 0, 0, "R4");      // exponent clipped: 67 / 35
    send_bit(4, 4, 0, 20, 0, "R5");     // stretched release
    send_bit(255, 255, 7, 0, 0, "R4");  // 8163 / 8163
    send_bit(1, 6, 3, 0, 1, "R7");      // last bit, then idle
    repeat (last_span) @(negedge clk);
    idle_check("R7", 40);

    send_bit(7, 2, 2, 0, 0, "R7");      // restart from idle
    send_bit(3, 3, 1, 3, 1, "R7");
    repeat (last_span) @(negedge clk);
    idle_check("R7", 20);
    chk(q.size() == 0, "R7 bits left over", q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule